// File: doc/BRIEF.md
# Two-Stage Clock-Crossing Stream Buffer

This block carries a stream of data words from a producer clocked by one clock into a consumer clocked by an unrelated clock. It also adds extra storage on the consumer side. The first stage is a small clock-crossing queue. Its occupancy is tracked with binary pointers. Only the Gray-coded copies of those pointers cross between the domains, each through two flip-flops. The write side raises its full flag from its own pointer and the synchronised read pointer. The read side raises its empty flag from its own pointer and the synchronised write pointer. Because of the synchroniser delay, either flag may assert early, but neither can assert late.

The second stage is a single-clock queue in the read domain. A small controller runs it in three phases: idle, collect and drain. While collecting, the controller moves one word per read cycle from the first stage into the second stage. It does so only when the first stage holds data and the second stage has room. When no move is possible, the controller switches to draining. During a drain it presents every stored word on the output, in order, one per cycle, until the second stage is empty. It then returns to idle. A producer writes with `wr_en` whenever the crossing stage is not full. The consumer takes every cycle in which `out_valid` is high. The output has no backpressure.

Top module: `cdc_cascade_buffer`

## Requirements
- R1: Every word accepted on the write side leaves on `out_data` exactly once and unchanged, in the order in which it was written.
- R2: Each pointer that crosses between the domains changes at most one bit per clock of its own domain, because it is Gray-coded as `b ^ (b >> 1)` of its binary pointer.
- R3: `xq_full` is 1 on the write clock after the crossing stage has accepted 2**XQ_AW words that the read side has not yet removed. A write attempted while `xq_full` is 1 is dropped: the write pointer does not move, and the word never appears at the output.
- R4: `xq_empty` and `lq_empty` are 1 once every accepted word has been delivered. While `xq_empty` is 1, the crossing stage's read pointer does not move.
- R5: `wr_overflow` becomes 1 on the first write attempted while `xq_full` is 1, and then stays 1 until `wr_rst_n` is asserted.
- R6: A word moves from the first stage into the second stage only when the first stage is not empty, the second stage is not full and the controller is not draining. No word is lost or duplicated by the move.
- R7: The controller goes from idle to collect on the first move. It goes from collect to drain in the first cycle with no move. It goes from drain back to idle in the cycle in which the second stage is empty. A drain emits the stored words on consecutive cycles, so a drain that follows a full second stage gives a run of exactly 2**LQ_AW valid cycles.
- R8: `out_valid` is high for exactly one read-clock cycle per delivered word, in the cycle after the controller pops that word.
- R9: While both resets are asserted: `out_valid`, `xq_full`, `lq_full` and `wr_overflow` are 0, and `xq_empty` and `lq_empty` are 1.
- R10: `lq_full` is 1 while the second stage holds 2**LQ_AW words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Active-low reset of the write domain |
| wr_en | input | 1 | Write request for `wr_data` |
| wr_data | input | DW | Word offered by the producer |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Active-low reset of the read domain |
| out_data | output | DW | Delivered word |
| out_valid | output | 1 | One-cycle strobe per delivered word |
| xq_full | output | 1 | Crossing stage full (write domain) |
| xq_empty | output | 1 | Crossing stage empty (read domain) |
| wr_overflow | output | 1 | Sticky: a write was attempted while full |
| lq_full | output | 1 | Second stage full (read domain) |
| lq_empty | output | 1 | Second stage empty (read domain) |

## Verification
The bench builds the block with 8-bit words, an 8-deep crossing stage and a 16-deep second stage. With these sizes both queues reach full within a few dozen words. The write clock runs at twice the read rate, with an offset in phase. So the producer outruns the consumer, and the write side sees real backpressure from the crossing stage's full flag. Holding the read domain in reset lets the crossing stage fill to exactly its depth, which makes the full boundary and the dropped writes exact. A long stream then collects 16 words and drains them as a single run.

// File: rtl/cdcb_pkg.sv
package cdcb_pkg;

  // One-hot phases of the second-stage controller.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b001,
    ST_FILL  = 3'b010,
    ST_DRAIN = 3'b100
  } drain_state_t;

endpackage

// File: rtl/gray_sync.sv
// Two-flop synchroniser for a Gray-coded vector.
module gray_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/xdom_fifo.sv
// Dual-clock queue with Gray pointers crossing through two-flop synchronisers.
module xdom_fifo #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wfull,
  output logic          wovf,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          rempty,
  output logic [AW:0]   wbin_o,
  output logic [AW:0]   wgray_o,
  output logic [AW:0]   rbin_o,
  output logic [AW:0]   rgray_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Full: wrapped once more than the reader, same slot.
  function automatic logic ptrs_full(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return (w[PW-1] != r[PW-1]) && (w[PW-2:0] == r[PW-2:0]);
  endfunction

  function automatic logic ptrs_empty(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w == r;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, rgray_ws, rbin_ws, wbin_nx;
  logic          wpush;

  gray_sync #(.W(PW)) u_rsync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_o), .q(rgray_ws)
  );

  always_comb begin
    rbin_ws = from_gray(rgray_ws);
    wfull   = ptrs_full(wbin, rbin_ws);
    wpush   = wen && !wfull;
    wbin_nx = wbin + PW'(wpush);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      wovf  <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
      if (wen && wfull) wovf <= 1'b1;
    end
  end

  always_ff @(posedge wclk) begin
    if (wpush) mem[wbin[AW-1:0]] <= wdata;
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rgray, wgray_rs, wbin_rs, rbin_nx;
  logic          rpop;

  gray_sync #(.W(PW)) u_wsync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_rs)
  );

  always_comb begin
    wbin_rs = from_gray(wgray_rs);
    rempty  = ptrs_empty(wbin_rs, rbin);
    rpop    = ren && !rempty;
    rbin_nx = rbin + PW'(rpop);
    rdata   = mem[rbin[AW-1:0]];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
    end
  end

  assign wbin_o  = wbin;
  assign wgray_o = wgray;
  assign rbin_o  = rbin;
  assign rgray_o = rgray;
endmodule

// File: rtl/local_fifo.sv
// Single-clock queue with occupancy count and registered read data.
module local_fifo #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  always_comb begin
    full  = (cnt == FULL_CNT);
    empty = (cnt == '0);
    do_wr = push && !full;
    do_rd = pop && !empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      rdata <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) begin
        rp    <= rp + 1'b1;
        rdata <= mem[rp];
      end
      unique case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end
endmodule

// File: rtl/drain_ctrl.sv
// Collect-then-drain controller for the second stage.
module drain_ctrl
  import cdcb_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_empty,
  input  logic         dst_full,
  input  logic         dst_empty,
  output logic         xfer,
  output logic         pop,
  output logic         valid,
  output drain_state_t state
);
  drain_state_t nxt;

  always_comb begin
    xfer = (state != ST_DRAIN) && !src_empty && !dst_full;
    pop  = (state == ST_DRAIN) && !dst_empty;
    nxt  = state;
    unique case (state)
      ST_IDLE:  if (xfer)      nxt = ST_FILL;
      ST_FILL:  if (!xfer)     nxt = ST_DRAIN;
      ST_DRAIN: if (dst_empty) nxt = ST_IDLE;
      default:                 nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      valid <= 1'b0;
    end else begin
      state <= nxt;
      valid <= pop;
    end
  end
endmodule

// File: rtl/cdc_cascade_buffer.sv
module cdc_cascade_buffer
  import cdcb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int XQ_AW = 3,
  parameter int LQ_AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          xq_full,
  output logic          xq_empty,
  output logic          wr_overflow,
  output logic          lq_full,
  output logic          lq_empty
);
  localparam int XPW = XQ_AW + 1;

  // Named internal events for the checker.
  logic [DW-1:0]  s1_rdata;
  logic [XPW-1:0] s1_wbin, s1_wgray, s1_rbin, s1_rgray;
  logic           s2_push, s2_pop;
  drain_state_t   ctl_state;

  xdom_fifo #(.DW(DW), .AW(XQ_AW)) u_xq (
    .wclk   (wr_clk),
    .wrst_n (wr_rst_n),
    .wen    (wr_en),
    .wdata  (wr_data),
    .wfull  (xq_full),
    .wovf   (wr_overflow),
    .rclk   (rd_clk),
    .rrst_n (rd_rst_n),
    .ren    (s2_push),
    .rdata  (s1_rdata),
    .rempty (xq_empty),
    .wbin_o (s1_wbin),
    .wgray_o(s1_wgray),
    .rbin_o (s1_rbin),
    .rgray_o(s1_rgray)
  );

  drain_ctrl u_ctl (
    .clk      (rd_clk),
    .rst_n    (rd_rst_n),
    .src_empty(xq_empty),
    .dst_full (lq_full),
    .dst_empty(lq_empty),
    .xfer     (s2_push),
    .pop      (s2_pop),
    .valid    (out_valid),
    .state    (ctl_state)
  );

  local_fifo #(.DW(DW), .AW(LQ_AW)) u_lq (
    .clk  (rd_clk),
    .rst_n(rd_rst_n),
    .push (s2_push),
    .wdata(s1_rdata),
    .pop  (s2_pop),
    .rdata(out_data),
    .full (lq_full),
    .empty(lq_empty)
  );
endmodule

// File: rtl/cdc_cascade_buffer_chk.sv
module cdc_cascade_buffer_chk #(
  parameter int PW = 4
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          wr_en,
  input logic          xq_full,
  input logic          wr_overflow,
  input logic          xq_empty,
  input logic          lq_empty,
  input logic          out_valid,
  input logic [PW-1:0] s1_wbin,
  input logic [PW-1:0] s1_wgray,
  input logic [PW-1:0] s1_rbin,
  input logic [PW-1:0] s1_rgray,
  input logic          s2_push,
  input logic          s2_pop,
  input logic [2:0]    ctl_state
);
  assert_wgray_step_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(s1_wgray ^ $past(s1_wgray)) <= 1);

  assert_rgray_step_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(s1_rgray ^ $past(s1_rgray)) <= 1);

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && xq_full) |=> $stable(s1_wbin));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    xq_empty |=> $stable(s1_rbin));

  assert_sticky_ovf_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_overflow |=> wr_overflow);

  assert_push_fills_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (s2_push && !s2_pop) |=> !lq_empty);

  assert_drain_exit_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (ctl_state == 3'b100 && lq_empty) |=> (ctl_state == 3'b001));

  assert_valid_after_pop_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    s2_pop |=> out_valid);

  assert_no_stray_valid_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !s2_pop |=> !out_valid);
endmodule

bind cdc_cascade_buffer cdc_cascade_buffer_chk #(.PW(XQ_AW + 1)) u_chk (
  .wr_clk     (wr_clk),
  .wr_rst_n   (wr_rst_n),
  .rd_clk     (rd_clk),
  .rd_rst_n   (rd_rst_n),
  .wr_en      (wr_en),
  .xq_full    (xq_full),
  .wr_overflow(wr_overflow),
  .xq_empty   (xq_empty),
  .lq_empty   (lq_empty),
  .out_valid  (out_valid),
  .s1_wbin    (s1_wbin),
  .s1_wgray   (s1_wgray),
  .s1_rbin    (s1_rbin),
  .s1_rgray   (s1_rgray),
  .s2_push    (s2_push),
  .s2_pop     (s2_pop),
  .ctl_state  (ctl_state)
);

// File: tb/cdc_cascade_buffer_tb.sv
`timescale 1ns/1ps
module cdc_cascade_buffer_tb;
  localparam int DW = 8;
  localparam int XQ_AW = 3;
  localparam int LQ_AW = 4;
  localparam int XQ_DEPTH = 1 << XQ_AW;
  localparam int LQ_DEPTH = 1 << LQ_AW;
  localparam time WR_PERIOD = 10ns;
  localparam time RD_PERIOD = 20ns;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] out_data;
  logic out_valid, xq_full, xq_empty, wr_overflow, lq_full, lq_empty;

  int checks = 0, errors = 0;
  int n_out = 0, run = 0, max_run = 0;
  bit lq_full_seen = 0, xq_full_seen = 0;
  logic [DW-1:0] exp_q[$];

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  initial begin
    #3ns;
    forever #(RD_PERIOD/2) rd_clk = ~rd_clk;
  end

  cdc_cascade_buffer #(.DW(DW), .XQ_AW(XQ_AW), .LQ_AW(LQ_AW)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .out_data(out_data), .out_valid(out_valid),
    .xq_full(xq_full), .xq_empty(xq_empty), .wr_overflow(wr_overflow),
    .lq_full(lq_full), .lq_empty(lq_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: every delivered word is compared against the queue (R1, R8).
  always @(negedge rd_clk) begin
    if (rd_rst_n) begin
      if (lq_full) lq_full_seen = 1;
      if (out_valid) begin
        run++;
        n_out++;
        if (exp_q.size() == 0) begin
          check(0, "R8 valid with nothing pending", 1, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(out_data == e, "R1 word order/value", out_data, e);
        end
      end else begin
        if (run > max_run) max_run = run;
        run = 0;
      end
    end
  end

  always @(negedge wr_clk) if (wr_rst_n && xq_full) xq_full_seen = 1;

  // Drives one write at a negedge; waits for room unless a forced (droppable) write.
  task automatic put(input logic [DW-1:0] d, input bit force_wr);
    @(negedge wr_clk);
    while (xq_full && !force_wr) @(negedge wr_clk);
    if (!xq_full) exp_q.push_back(d);
    wr_en = 1;
    wr_data = d;
  endtask

  task automatic stop_wr();
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic wait_drained();
    int t = 0;
    while (exp_q.size() != 0 && t < 4000) begin
      @(negedge rd_clk);
      t++;
    end
    repeat (40) @(negedge rd_clk);
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(negedge rd_clk);
    // R9: reset state
    check(out_valid == 0, "R9 out_valid", out_valid, 0);
    check(xq_full == 0, "R9 xq_full", xq_full, 0);
    check(lq_full == 0, "R9 lq_full", lq_full, 0);
    check(wr_overflow == 0, "R9 wr_overflow", wr_overflow, 0);
    check(xq_empty == 1, "R9 xq_empty", xq_empty, 1);
    check(lq_empty == 1, "R9 lq_empty", lq_empty, 1);

    // R3/R5: read domain held in reset, crossing stage fills to its depth.
    @(negedge wr_clk) wr_rst_n = 1;
    repeat (3) @(negedge wr_clk);
    for (int i = 0; i < XQ_DEPTH - 1; i++) put(DW'(8'h40 + i), 0);
    stop_wr();
    check(xq_full == 0, "R3 not full one short of depth", xq_full, 0);
    put(DW'(8'h40 + XQ_DEPTH - 1), 0);
    stop_wr();
    check(xq_full == 1, "R3 full at depth", xq_full, 1);
    check(wr_overflow == 0, "R5 no overflow before drop", wr_overflow, 0);
    for (int i = 0; i < 3; i++) put(DW'(8'hE0 + i), 1);
    stop_wr();
    check(wr_overflow == 1, "R5 overflow set by dropped write", wr_overflow, 1);
    check(xq_full == 1, "R3 still full after dropped writes", xq_full, 1);
    base = n_out;
    @(negedge rd_clk) rd_rst_n = 1;
    wait_drained();
    check(n_out - base == XQ_DEPTH, "R3 dropped words never delivered", n_out - base, XQ_DEPTH);
    check(xq_empty == 1, "R4 xq_empty after drain", xq_empty, 1);
    check(lq_empty == 1, "R4 lq_empty after drain", lq_empty, 1);
    check(wr_overflow == 1, "R5 overflow sticky", wr_overflow, 1);

    // R5: reset clears the sticky flag (both domains reset together).
    @(negedge wr_clk) begin wr_rst_n = 0; rd_rst_n = 0; end
    repeat (4) @(negedge rd_clk);
    check(wr_overflow == 0, "R5 overflow cleared by reset", wr_overflow, 0);
    @(negedge wr_clk) wr_rst_n = 1;
    @(negedge rd_clk) rd_rst_n = 1;
    repeat (3) @(negedge rd_clk);

    // R1/R2: ten sequential words across the 2:1, phase-shifted clocks.
    base = n_out;
    for (int i = 1; i <= 10; i++) put(DW'(i), 0);
    stop_wr();
    wait_drained();
    check(n_out - base == 10, "R1 ten-word burst count", n_out - base, 10);
    check(exp_q.size() == 0, "R2 all crossed words delivered", exp_q.size(), 0);

    // R6/R7/R10: long stream, writer outpaces reader.
    base = n_out;
    max_run = 0;
    lq_full_seen = 0;
    xq_full_seen = 0;
    for (int i = 0; i < 64; i++) put(DW'(i * 37 + 5), 0);
    stop_wr();
    wait_drained();
    check(n_out - base == 64, "R6 no loss or duplication", n_out - base, 64);
    check(lq_full_seen == 1, "R10 second stage reached full", lq_full_seen, 1);
    check(max_run == LQ_DEPTH, "R7 drain run equals second-stage depth", max_run, LQ_DEPTH);
    check(xq_full_seen == 1, "R3 writer throttled by full", xq_full_seen, 1);
    check(xq_empty == 1 && lq_empty == 1, "R4 both empty at end", {xq_empty, lq_empty}, 3);
    check(out_valid == 0, "R8 no valid when idle", out_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule